// File: doc/BRIEF.md
# Charge Rate Pulse Modulator

This block drives the on/off gate of the charge current switch for one battery channel. A charge sequencer above it chooses the charge phase, and this block only shapes the gate for that phase. In fast charge the gate follows an external current-regulation request. In the reduced-rate phases that come after fast charge, the block makes the pattern itself. Top-off uses a long fixed on/off cycle that gives about one eighth of the fast rate. Pulse trickle, which is also used while a channel waits with an over-discharged pack, sends one short pulse of fixed width per period.

All timing is counted in ticks of a prescaled time-base input, so a short tick period can be used in simulation. The trickle period is the pulse width divided by the target average fraction: 32 widths when top-off is disabled and 64 widths when it is enabled. A zero configuration code turns off both reduced-rate schemes. This block does not measure current or temperature and does not decide when a phase ends; the sequencer owns the phase length.

Top module: `cpm_gate_modulator`

## Requirements
- R1: While reset is asserted, at each clock edge the gate output is driven low.
- R2: With phase code 0 (idle), or any unused phase code 5 to 7, the gate is low one clock after that phase is presented, whatever the other inputs are.
- R3: In phase code 1 (fast), the gate equals the regulation request sampled at the previous clock edge.
- R4: In phase code 2 (top-off), with a nonzero configuration code and top-off enabled, the gate is high for TOP_ON_TICKS ticks and then low for TOP_OFF_TICKS ticks, and this cycle repeats.
- R5: In top-off phase, the gate stays low if top-off is disabled or the configuration code is 0.
- R6: In phase code 3 (trickle), with a nonzero configuration code and top-off disabled, the gate is high for TRK_ON_TICKS ticks once in every 32*TRK_ON_TICKS ticks.
- R7: In trickle phase with top-off enabled, the period is 64*TRK_ON_TICKS ticks and the high time does not change.
- R8: Phase code 4 (pending) gives the same pulse pattern as trickle, and follows the same top-off rule for its period.
- R9: In trickle or pending phase with configuration code 0, the gate stays low.
- R10: Each change of phase code restarts the pattern. The first gate value after the change is the start of the on interval.
- R11: The pattern position moves forward only on clock edges where tick is high. With tick low, the gate holds its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaled time-base strobe, one clock wide |
| phase_i | input | 3 | Charge phase: 0 idle, 1 fast, 2 top-off, 3 trickle, 4 pending |
| cfg_i | input | 2 | Rate configuration code; 0 disables top-off and trickle |
| topoff_en_i | input | 1 | Top-off enabled; doubles the trickle period |
| reg_req_i | input | 1 | Current-regulation request passed through in fast phase |
| gate_en_o | output | 1 | Charge current gate enable (registered) |

## Verification
Every result comes from the output register, so the response to any input is due at the first rising edge after that input is presented. The bench changes inputs just after a falling edge and reads the gate at the next falling edge, which means each sample is exactly one edge after its stimulus. For pattern phases, the value read k edges after a phase change, with the tick held high, is the pattern at position k modulo the period. The expected high counts and per-position values are worked out from that rule. Tick-gating tests hold tick low and check that the sampled value stays unchanged over many edges.

// File: rtl/cpm_pkg.sv
// Package: shared phase encoding for the charge rate pulse modulator.
// Assumes the sequencer drives exactly these codes; others count as idle.
package cpm_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_FAST    = 3'd1,
        PH_TOPOFF  = 3'd2,
        PH_TRICKLE = 3'd3,
        PH_PENDING = 3'd4
    } phase_e;
endpackage

// File: rtl/cpm_mode_decode.sv
// Module: cpm_mode_decode
// Picks what the gate does for the current phase: pass the regulation
// request through, run a timed pattern (with its on length and period),
// or stay low. Pure combinational logic; assumes on lengths are nonzero.
module cpm_mode_decode #(
    parameter int CNT_W        = 8,
    parameter int TOP_ON_TICKS = 4,
    parameter int TOP_PER      = 34,
    parameter int TRK_ON_TICKS = 2
) (
    input  logic [2:0]       phase_i,
    input  logic [1:0]       cfg_i,
    input  logic             topoff_en_i,
    output logic             pass_req_o,
    output logic             use_pattern_o,
    output logic [CNT_W-1:0] on_len_o,
    output logic [CNT_W-1:0] period_o
);
    import cpm_pkg::*;

    localparam logic [CNT_W-1:0] TOP_ON_C   = CNT_W'(TOP_ON_TICKS);
    localparam logic [CNT_W-1:0] TOP_PER_C  = CNT_W'(TOP_PER);
    localparam logic [CNT_W-1:0] TRK_ON_C   = CNT_W'(TRK_ON_TICKS);
    localparam logic [CNT_W-1:0] TRK_PER_32 = CNT_W'(TRK_ON_TICKS * 32);
    localparam logic [CNT_W-1:0] TRK_PER_64 = CNT_W'(TRK_ON_TICKS * 64);

    logic rate_cfg_on;
    assign rate_cfg_on = (cfg_i != 2'b00);

    // Map phase and configuration to gate source, on length and period.
    always_comb begin
        pass_req_o    = 1'b0;
        use_pattern_o = 1'b0;
        on_len_o      = TRK_ON_C;
        period_o      = topoff_en_i ? TRK_PER_64 : TRK_PER_32;
        case (phase_i)
            PH_FAST: pass_req_o = 1'b1;
            PH_TOPOFF: begin
                use_pattern_o = rate_cfg_on && topoff_en_i;
                on_len_o      = TOP_ON_C;
                period_o      = TOP_PER_C;
            end
            PH_TRICKLE, PH_PENDING: use_pattern_o = rate_cfg_on;
            default: ;
        endcase
    end
endmodule

// File: rtl/cpm_interval_counter.sv
// Module: cpm_interval_counter
// Counts ticks inside one pattern period and reports the position that
// will be current after the next clock edge. A restart forces position 0.
// Assumes period >= 1; a count left beyond a shortened period wraps on
// the next tick.
module cpm_interval_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] pos_next_o
);
    logic [CNT_W-1:0] cnt_q;

    // Next position: restart, wrap at end of period, or advance on tick.
    always_comb begin
        if (restart_i)
            pos_next_o = '0;
        else if (tick_i)
            pos_next_o = (cnt_q >= period_i - 1'b1) ? '0 : cnt_q + 1'b1;
        else
            pos_next_o = cnt_q;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= pos_next_o;
    end

    p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> (cnt_q == $past(cnt_q)));

    p_restart_to_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/cpm_gate_modulator.sv
// Module: cpm_gate_modulator (top)
// Gate generator for one battery channel. Fast phase passes the
// regulation request through; top-off, trickle and pending run timed
// on/off patterns counted in ticks; idle and unused codes hold the gate
// low. Output is registered. Assumes tick_i is a one-clock strobe.
module cpm_gate_modulator #(
    parameter int TOP_ON_TICKS  = 400000,
    parameter int TOP_OFF_TICKS = 3000000,
    parameter int TRK_ON_TICKS  = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [2:0] phase_i,
    input  logic [1:0] cfg_i,
    input  logic       topoff_en_i,
    input  logic       reg_req_i,
    output logic       gate_en_o
);
    import cpm_pkg::*;

    localparam int TOP_PER  = TOP_ON_TICKS + TOP_OFF_TICKS;
    localparam int TRK_SLOW = TRK_ON_TICKS * 64;
    localparam int MAX_PER  = (TOP_PER > TRK_SLOW) ? TOP_PER : TRK_SLOW;
    localparam int CNT_W    = $clog2(MAX_PER + 1);

    logic [2:0]       phase_q;
    logic             restart;
    logic             pass_req;
    logic             use_pattern;
    logic [CNT_W-1:0] on_len;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] pos_next;
    logic             gate_d;

    // Remember the last phase so a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_i;
    end

    assign restart = (phase_i != phase_q);

    cpm_mode_decode #(
        .CNT_W        (CNT_W),
        .TOP_ON_TICKS (TOP_ON_TICKS),
        .TOP_PER      (TOP_PER),
        .TRK_ON_TICKS (TRK_ON_TICKS)
    ) decode_i (
        .phase_i       (phase_i),
        .cfg_i         (cfg_i),
        .topoff_en_i   (topoff_en_i),
        .pass_req_o    (pass_req),
        .use_pattern_o (use_pattern),
        .on_len_o      (on_len),
        .period_o      (period)
    );

    cpm_interval_counter #(
        .CNT_W (CNT_W)
    ) counter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .restart_i  (restart),
        .period_i   (period),
        .pos_next_o (pos_next)
    );

    // Gate value for the coming cycle.
    always_comb begin
        if (pass_req)         gate_d = reg_req_i;
        else if (use_pattern) gate_d = (pos_next < on_len);
        else                  gate_d = 1'b0;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_en_o <= 1'b0;
        else        gate_en_o <= gate_d;
    end

    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_IDLE || phase_i > PH_PENDING) |=> !gate_en_o);

    p_fast_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_FAST) |=> (gate_en_o == $past(reg_req_i)));

    p_topoff_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_TOPOFF && (!topoff_en_i || cfg_i == 2'b00)) |=> !gate_en_o);

    p_trickle_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_i == PH_TRICKLE || phase_i == PH_PENDING) && cfg_i == 2'b00)
        |=> !gate_en_o);

    p_restart_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && use_pattern) |=> gate_en_o);
endmodule

// File: tb/cpm_gate_modulator_tb_top.sv
module cpm_gate_modulator_tb_top;
    localparam int TOP_ON  = 4;
    localparam int TOP_OFF = 30;
    localparam int TRK_ON  = 2;
    localparam int NROWS   = 12;

    // Row layout: phase[23:21] cfg[20:19] topoff_en[18] req[17]
    //             cycles[16:9] expected_highs[8:1] expected_first[0]
    localparam logic [23:0] VEC [NROWS] = '{
        {3'd2, 2'd1, 1'b1, 1'b0, 8'd68,  8'd8,  1'b1},
        {3'd2, 2'd1, 1'b0, 1'b0, 8'd34,  8'd0,  1'b0},
        {3'd2, 2'd0, 1'b1, 1'b0, 8'd34,  8'd0,  1'b0},
        {3'd3, 2'd2, 1'b0, 1'b0, 8'd128, 8'd4,  1'b1},
        {3'd3, 2'd3, 1'b1, 1'b0, 8'd128, 8'd2,  1'b1},
        {3'd4, 2'd1, 1'b0, 1'b0, 8'd64,  8'd2,  1'b1},
        {3'd4, 2'd1, 1'b1, 1'b0, 8'd128, 8'd2,  1'b1},
        {3'd3, 2'd0, 1'b0, 1'b0, 8'd64,  8'd0,  1'b0},
        {3'd1, 2'd1, 1'b0, 1'b1, 8'd10,  8'd10, 1'b1},
        {3'd1, 2'd1, 1'b0, 1'b0, 8'd10,  8'd0,  1'b0},
        {3'd0, 2'd3, 1'b1, 1'b1, 8'd10,  8'd0,  1'b0},
        {3'd7, 2'd3, 1'b1, 1'b1, 8'd10,  8'd0,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] phase = 3'd0;
    logic [1:0] cfg = 2'd0;
    logic       topoff_en = 1'b0;
    logic       reg_req = 1'b0;
    logic       gate_en;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cpm_gate_modulator #(
        .TOP_ON_TICKS  (TOP_ON),
        .TOP_OFF_TICKS (TOP_OFF),
        .TRK_ON_TICKS  (TRK_ON)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .phase_i     (phase),
        .cfg_i       (cfg),
        .topoff_en_i (topoff_en),
        .reg_req_i   (reg_req),
        .gate_en_o   (gate_en)
    );

    function automatic string row_req(int i);
        case (i)
            0: return "R4";
            1, 2: return "R5";
            3: return "R6";
            4: return "R7";
            5, 6: return "R8";
            7: return "R9";
            8, 9: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One rising edge, then sample at the following falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int highs;
        int first;
        // R1: gate low during reset even with fast phase and request high
        @(negedge clk);
        phase = 3'd1; reg_req = 1'b1; tick = 1'b1;
        repeat (3) step();
        check("R1", gate_en, 0);
        phase = 3'd0; reg_req = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R1", gate_en, 0);

        // Vector table walk, tick high every cycle
        for (int i = 0; i < NROWS; i++) begin
            phase = 3'd0; tick = 1'b1;
            step();
            phase     = VEC[i][23:21];
            cfg       = VEC[i][20:19];
            topoff_en = VEC[i][18];
            reg_req   = VEC[i][17];
            highs = 0; first = 0;
            for (int k = 0; k < int'(VEC[i][16:9]); k++) begin
                step();
                if (k == 0) first = int'(gate_en);
                if (gate_en) highs++;
            end
            check(row_req(i), highs, int'(VEC[i][8:1]));
            if (VEC[i][0]) check("R10", first, 1);
        end

        // R4: exact top-off shape, position by position
        phase = 3'd0; step();
        phase = 3'd2; cfg = 2'd1; topoff_en = 1'b1; tick = 1'b1;
        for (int k = 0; k < TOP_ON + TOP_OFF; k++) begin
            step();
            check("R4", int'(gate_en), (k < TOP_ON) ? 1 : 0);
        end

        // R10: phase change during top-off off interval restarts on-time
        phase = 3'd0; step();
        phase = 3'd2; cfg = 2'd1; topoff_en = 1'b1;
        repeat (10) step();
        check("R4", gate_en, 0);
        phase = 3'd4; topoff_en = 1'b0;
        step();
        check("R10", gate_en, 1);

        // R11: no tick means no progress
        phase = 3'd0; step();
        phase = 3'd3; cfg = 2'd1; topoff_en = 1'b0; tick = 1'b0;
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            step();
            if (gate_en) highs++;
        end
        check("R11", highs, 10);
        tick = 1'b1;
        step();
        check("R11", gate_en, 1);
        step();
        check("R11", gate_en, 0);
        tick = 1'b0;
        highs = 0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (gate_en) highs++;
        end
        check("R11", highs, 0);

        // R3: one-edge latency of the request in fast phase
        phase = 3'd1; reg_req = 1'b0; tick = 1'b1;
        step();
        check("R3", gate_en, 0);
        reg_req = 1'b1;
        step();
        check("R3", gate_en, 1);
        reg_req = 1'b0;
        step();
        check("R3", gate_en, 0);

        // R2: dropping to idle while gate is high
        reg_req = 1'b1; step();
        phase = 3'd0;
        step();
        check("R2", gate_en, 0);

        finish_run();
    end
endmodule